// File: doc/BRIEF.md
# CPU-Cycle Interrupt Timer with Byte-Toggle Load

This block is a 16-bit down-counter that steps once per CPU clock and raises an interrupt request when it passes below zero. Software reaches it through a plain write port (address, data, strobe). One decoded address loads the live count one byte at a time, high byte first, through an internal byte toggle. A second decoded address carries the run/pause bit, clears the pending interrupt and rearms the toggle.

No reload register exists. The bytes written become the running count directly. When the count steps from zero to all-ones, the interrupt line is set and the run bit clears itself, so the counter stops at all-ones until software enables it again. The live count is also brought out as a debug output.

Top module: `cyc_irq_timer`

## Requirements
- R1: After a synchronous reset, the count is 0, the counter is paused, `irq` is low, and the next load write targets the high byte.
- R2: Addresses are decoded through the mask 0xF800. A write acts as a load write when (addr & 0xF800) == 0xC800 and as a control write when (addr & 0xF800) == 0xD800. Writes to any other address change neither the count, the run state nor `irq`.
- R3: Load writes alternate between bytes. The first after reset or after a control write replaces count[15:8], the next replaces count[7:0], and so on.
- R4: A load write replaces its byte of the live count at the next clock edge. In that cycle the count is not decremented.
- R5: Bit 4 of a control write sets the run state (1 = run, 0 = pause). While paused, the count holds.
- R6: While running and with no load write, the count decreases by one on each clock edge.
- R7: At a running step from 0x0000, the count becomes 0xFFFF, `irq` goes high and the run state clears.
- R8: Once set, `irq` stays high through idle cycles and load writes until a control write or reset.
- R9: A control write drives `irq` low at the next edge and returns the byte toggle to the high byte.
- R10: Enabling again at 0xFFFF without reloading gives the next `irq` exactly 65536 clock edges after the enabling write's edge.
- R11: When a control write falls on the wrap cycle, the count still wraps, but the written run bit takes effect and `irq` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU-cycle clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 16 | Write address |
| wr_data | input | 8 | Write data |
| irq | output | 1 | Interrupt request, active high, held until acknowledged |
| count | output | 16 | Live count (debug) |

## Verification
The assertions assume that `wr_addr` and `wr_data` carry known values whenever `wr_en` is high, and that every write strobe lasts exactly one clock. They also assume reset is held for at least one edge before the first write. The stimulus changes every input only on the falling clock edge, and it drops the strobe after one cycle. It includes mirror addresses inside both decoded windows, addresses just outside them, a control write placed on the wrap edge, and load writes while `irq` is pending. This keeps the inputs inside those assumptions while still reaching the corner cases.

// File: rtl/cyc_timer_pkg.sv
package cyc_timer_pkg;

    localparam int unsigned CNT_W  = 16;
    localparam int unsigned ADDR_W = 16;
    localparam int unsigned DATA_W = 8;

    typedef struct packed {
        logic load;
        logic ctrl;
    } wr_sel_t;

    typedef enum logic {
        BYTE_HI = 1'b0,
        BYTE_LO = 1'b1
    } byte_sel_e;

    function automatic wr_sel_t decode_wr(
        input logic              en,
        input logic [ADDR_W-1:0] addr,
        input logic [ADDR_W-1:0] mask,
        input logic [ADDR_W-1:0] load_addr,
        input logic [ADDR_W-1:0] ctrl_addr
    );
        wr_sel_t s;
        s.load = en && ((addr & mask) == load_addr);
        s.ctrl = en && ((addr & mask) == ctrl_addr);
        return s;
    endfunction

endpackage

// File: rtl/cyc_wr_decode.sv
module cyc_wr_decode
    import cyc_timer_pkg::*;
#(
    parameter int unsigned            AW        = ADDR_W,
    parameter logic [AW-1:0]          DEC_MASK  = 16'hF800,
    parameter logic [AW-1:0]          LOAD_ADDR = 16'hC800,
    parameter logic [AW-1:0]          CTRL_ADDR = 16'hD800
) (
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    output wr_sel_t       sel
);
    always_comb begin
        sel = decode_wr(wr_en, wr_addr, DEC_MASK, LOAD_ADDR, CTRL_ADDR);
    end
endmodule

// File: rtl/cyc_count_core.sv
module cyc_count_core
    import cyc_timer_pkg::*;
#(
    parameter int unsigned CW = CNT_W,
    parameter int unsigned DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          load_wr,
    input  logic          ctrl_wr,
    input  logic [DW-1:0] data,
    output logic [CW-1:0] count,
    output logic          wrap
);
    localparam logic [CW-1:0] ZERO = '0;
    localparam logic [CW-1:0] ONE  = CW'(1);

    byte_sel_e      tgl;
    logic [CW-1:0]  cnt_nx;

    assign wrap = run && !load_wr && (count == ZERO);

    always_comb begin
        cnt_nx = count;
        if (load_wr) begin
            if (tgl == BYTE_HI) cnt_nx[CW-1 -: DW] = data;
            else                cnt_nx[DW-1:0]     = data;
        end else if (run) begin
            cnt_nx = count - ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= ZERO;
            tgl   <= BYTE_HI;
        end else begin
            count <= cnt_nx;
            if (ctrl_wr)      tgl <= BYTE_HI;
            else if (load_wr) tgl <= (tgl == BYTE_HI) ? BYTE_LO : BYTE_HI;
        end
    end

    assert_hi_byte_R3: assert property (@(posedge clk) disable iff (rst)
        (load_wr && tgl == BYTE_HI) |=> (count[CW-1 -: DW] == $past(data)) && (tgl == BYTE_LO));
    assert_lo_byte_R3: assert property (@(posedge clk) disable iff (rst)
        (load_wr && tgl == BYTE_LO) |=> (count[DW-1:0] == $past(data)) && (tgl == BYTE_HI));
    assert_load_keeps_other_R4: assert property (@(posedge clk) disable iff (rst)
        (load_wr && tgl == BYTE_HI) |=> count[DW-1:0] == $past(count[DW-1:0]));
    assert_step_R6: assert property (@(posedge clk) disable iff (rst)
        (run && !load_wr) |=> count == $past(count) - ONE);
    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!run && !load_wr) |=> $stable(count));
    assert_toggle_rearm_R9: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |=> tgl == BYTE_HI);
endmodule

// File: rtl/cyc_irq_ctrl.sv
module cyc_irq_ctrl
    import cyc_timer_pkg::*;
#(
    parameter int unsigned DW      = DATA_W,
    parameter int unsigned RUN_BIT = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ctrl_wr,
    input  logic [DW-1:0] data,
    input  logic          wrap,
    output logic          run,
    output logic          irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            run <= 1'b0;
            irq <= 1'b0;
        end else if (ctrl_wr) begin
            run <= data[RUN_BIT];
            irq <= 1'b0;
        end else if (wrap) begin
            run <= 1'b0;
            irq <= 1'b1;
        end
    end

    assert_fire_R7: assert property (@(posedge clk) disable iff (rst)
        (wrap && !ctrl_wr) |=> irq && !run);
    assert_hold_irq_R8: assert property (@(posedge clk) disable iff (rst)
        (irq && !ctrl_wr) |=> irq);
    assert_ack_R9: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |=> !irq);
    assert_ctrl_wins_R11: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && wrap) |=> (run == $past(data[RUN_BIT])) && !irq);
    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (rst)
        (!irq && !wrap) |=> !irq);
endmodule

// File: rtl/cyc_irq_timer.sv
module cyc_irq_timer
    import cyc_timer_pkg::*;
#(
    parameter int unsigned       AW        = ADDR_W,
    parameter int unsigned       DW        = DATA_W,
    parameter int unsigned       CW        = CNT_W,
    parameter int unsigned       RUN_BIT   = 4,
    parameter logic [AW-1:0]     DEC_MASK  = 16'hF800,
    parameter logic [AW-1:0]     LOAD_ADDR = 16'hC800,
    parameter logic [AW-1:0]     CTRL_ADDR = 16'hD800
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic          irq,
    output logic [CW-1:0] count
);
    wr_sel_t sel;
    logic    run;
    logic    wrap;

    cyc_wr_decode #(
        .AW(AW), .DEC_MASK(DEC_MASK), .LOAD_ADDR(LOAD_ADDR), .CTRL_ADDR(CTRL_ADDR)
    ) u_dec (
        .wr_en(wr_en), .wr_addr(wr_addr), .sel(sel)
    );

    cyc_count_core #(.CW(CW), .DW(DW)) u_core (
        .clk(clk), .rst(rst), .run(run), .load_wr(sel.load), .ctrl_wr(sel.ctrl),
        .data(wr_data), .count(count), .wrap(wrap)
    );

    cyc_irq_ctrl #(.DW(DW), .RUN_BIT(RUN_BIT)) u_irq (
        .clk(clk), .rst(rst), .ctrl_wr(sel.ctrl), .data(wr_data), .wrap(wrap),
        .run(run), .irq(irq)
    );

    assert_one_target_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sel.load, sel.ctrl}));
    assert_reset_R1: assert property (@(posedge clk)
        $past(rst) |-> (count == '0) && !irq);
endmodule

// File: tb/sim_cyc_irq_timer.sv
module sim_cyc_irq_timer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        irq;
    logic [15:0] count;

    int n_chk = 0;
    int n_bad = 0;
    string tag = "R1";
    bit done = 0;

    int m_cnt, m_en, m_irq, m_hi;

    always #4 clk = ~clk;

    cyc_irq_timer u0 (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
                      .wr_data(wr_data), .irq(irq), .count(count));

    always @(posedge clk) begin
        int nc;
        bit ld, ct, fire;
        if (rst) begin
            m_cnt = 0; m_en = 0; m_irq = 0; m_hi = 1;
        end else begin
            ld = wr_en && ((wr_addr & 16'hF800) == 16'hC800);
            ct = wr_en && ((wr_addr & 16'hF800) == 16'hD800);
            nc = m_cnt; fire = 0;
            if (ld) begin
                if (m_hi != 0) nc = (int'(wr_data) << 8) | (m_cnt & 'hFF);
                else           nc = (m_cnt & 'hFF00) | int'(wr_data);
                m_hi = (m_hi != 0) ? 0 : 1;
            end else if (m_en != 0) begin
                if (m_cnt == 0) begin nc = 'hFFFF; fire = 1; end
                else nc = m_cnt - 1;
            end
            if (ct) begin
                m_en = int'(wr_data[4]); m_irq = 0; m_hi = 1;
            end else if (fire) begin
                m_en = 0; m_irq = 1;
            end
            m_cnt = nc;
        end
    end

    task automatic check(input string t, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            check({tag, " count"}, int'(count), m_cnt);
            check({tag, " irq"}, int'(irq), m_irq);
        end
    end

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        wr_addr = a; wr_data = d; wr_en = 1'b1;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        int k;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        tag = "R1";
        check("R1 reset count", int'(count), 0);
        check("R1 reset irq", int'(irq), 0);
        idle(2);

        tag = "R3";
        wr(16'hCFFF, 8'h12);
        check("R3 high byte", int'(count), 'h1200);
        wr(16'hC800, 8'h05);
        check("R3 low byte", int'(count), 'h1205);
        wr(16'hC900, 8'h00);
        wr(16'hC800, 8'h05);
        check("R3 alternation", int'(count), 'h0005);

        tag = "R6";
        wr(16'hD800, 8'h10);
        idle(3);
        check("R6 decrement", int'(count), 2);
        tag = "R7";
        idle(3);
        check("R7 wrap count", int'(count), 'hFFFF);
        check("R7 irq set", int'(irq), 1);
        idle(2);
        check("R7 stopped", int'(count), 'hFFFF);

        tag = "R8";
        wr(16'hC800, 8'h00);
        idle(4);
        check("R8 irq held through load", int'(irq), 1);

        tag = "R2";
        wr(16'hC000, 8'h33);
        wr(16'hE800, 8'h10);
        wr(16'h5800, 8'h10);
        check("R2 irq untouched", int'(irq), 1);
        check("R2 count untouched", int'(count), 'h00FF);

        tag = "R9";
        wr(16'hDFFF, 8'h00);
        check("R9 ack", int'(irq), 0);
        wr(16'hC800, 8'hAB);
        check("R9 toggle rearmed", int'(count), 'hABFF);
        wr(16'hC800, 8'h40);

        tag = "R5";
        idle(5);
        check("R5 paused holds", int'(count), 'hAB40);
        wr(16'hD800, 8'hEF);
        idle(3);
        check("R5 bit4 zero pauses", int'(count), 'hAB40);
        wr(16'hD800, 8'h10);
        idle(4);

        tag = "R4";
        wr(16'hC800, 8'h77);
        check("R4 load no decrement", int'(count) >> 8, 'h77);
        wr(16'hC800, 8'h02);
        check("R4 low load exact", int'(count), 'h7702);
        wr(16'hD800, 8'h00);

        tag = "R11";
        wr(16'hC800, 8'h00);
        wr(16'hC800, 8'h02);
        wr(16'hD800, 8'h10);
        idle(2);
        wr(16'hD800, 8'h10);
        check("R11 wrapped", int'(count), 'hFFFF);
        check("R11 irq suppressed", int'(irq), 0);
        idle(3);
        check("R11 still running", int'(count), 'hFFFC);
        wr(16'hD800, 8'h00);

        tag = "R10";
        wr(16'hC800, 8'h00);
        wr(16'hC800, 8'h00);
        wr(16'hD800, 8'h10);
        idle(1);
        wr(16'hD800, 8'h10);
        k = 0;
        do begin
            @(posedge clk); k++; @(negedge clk);
        end while (!irq && k < 70000);
        check("R10 full period", k, 65536);

        idle(2);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog R1 actual=timeout expected=finish");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule